// File: doc/BRIEF.md
# SPI Control Register File

This block is a serial slave register file for a board-management device. A host reaches it over a four-wire SPI link in mode 0. Every transaction is one 48-bit frame. The frame carries a read/write flag, a register offset and a 32-bit data word. The block samples the link pins with its own system clock. It reads them through two-stage synchronisers and detects the clock edges in that domain, so the link clock must be several times slower than the system clock.

The register file holds constant identification words, a build identifier and a 64-bit serial number split across two words. It also holds a handshake word for a link partner. One control word drives the board outputs: a PLL reference-clock enable, a clock enable for each of two daughterboards and a reset for each of two daughterboards. Each of these outputs has a "turn on" bit and a "turn off" bit in that word. A write therefore changes only the outputs it names, and software never has to read the word before writing it. Two status inputs come back through reads: the clock-running indication and the partner-detected indication.

Top module: `spi_ctrl_regs`

## Requirements
- R1: A frame is 48 bits, shifted MSB first while `spi_cs_n` is low. MOSI is sampled on rising `spi_sclk`. Bit 47 is the write flag (1 = write), bits 46:32 are the register offset and bits 31:0 are the data. A write commits on the 48th rising edge. Any further clock edges before `spi_cs_n` rises have no effect.
- R2: In a read frame, the 32-bit read word for the offset is driven on `spi_miso` MSB first. Each bit changes after a falling edge, so the host sees frame bit 31 at the 17th rising edge and bit 0 at the 48th. `spi_miso` is 0 during the header and whenever `spi_cs_n` is high.
- R3: Offset 0x00 reads 0x0A522D27. Offsets 0x04 and 0x08 both read 0x20122114.
- R4: Offset 0x10 reads the `BUILD_ID` parameter. Bits 27:0 hold the hash, and a nonzero value in bits 31:28 flags a build from a modified tree.
- R5: A write to 0x20 with bit 10 set turns `pll_ref_en_o` on, and one with bit 14 set turns it off. A read of 0x20 returns `clk_run_i` at bit 2 and `pll_ref_en_o` at bit 0.
- R6: A write to 0x20 with bit 8 or bit 9 set turns on `db_clk_en_o[0]` or `db_clk_en_o[1]`. Bit 12 or bit 13 turns them off. A read of 0x20 returns `db_clk_en_o` at bits 5:4.
- R7: A write to 0x20 with bit 16 or bit 17 set releases `db_rst_o[0]` or `db_rst_o[1]` (drives it to 0). Bit 20 or bit 21 asserts it (drives it to 1). A read of 0x20 returns `db_rst_o` at bits 7:6. All other bits of this read are 0.
- R8: In a write to 0x20, an output whose on/off pair has neither bit set, or both bits set, keeps its value.
- R9: Offsets 0x34 (low word) and 0x38 (high word) hold the serial number. They read back the last value written and are 0 after reset.
- R10: A write to 0x3C sets `dev_ready_o` to data bit 0. A read of 0x3C returns `partner_i` at bit 0, with the other bits 0.
- R11: A read of any offset not listed above returns 0. A write to a read-only or unlisted offset changes no register and no output.
- R12: After reset, `pll_ref_en_o`, `db_clk_en_o` and `dev_ready_o` are 0, and `db_rst_o` is 2'b11.
- R13: A frame that ends (`spi_cs_n` rising) before its 48th rising edge writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| clk_run_i | input | 1 | Status: reference clock running |
| partner_i | input | 1 | Status: upstream link partner detected |
| pll_ref_en_o | output | 1 | PLL reference-clock enable |
| db_clk_en_o | output | 2 | Daughterboard clock enables |
| db_rst_o | output | 2 | Daughterboard resets, 1 = held in reset |
| dev_ready_o | output | 1 | Device-ready flag to link partner |

## Verification
The assertions assume that the SPI pins change slowly compared with `clk`. Each level of `spi_sclk` must last longer than the synchroniser delay, so that every link edge is seen as exactly one detected edge. They also assume that `spi_mosi` settles before the rising edge that samples it. The stimulus holds each half period of `spi_sclk` for four system clocks. It changes `spi_mosi` only while `spi_sclk` is low, and it lowers `spi_cs_n` only while `spi_sclk` is low. The frames cover truncated frames, frames with extra clocks after bit 48, and both values of each status input.

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs #(
  parameter logic [31:0] BUILD_ID = 32'h0000_0000,
  parameter int          ADDR_W   = 15,
  parameter int          DATA_W   = 32,
  parameter int          NUM_DB   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              clk_run_i,
  input  logic              partner_i,
  output logic              pll_ref_en_o,
  output logic [NUM_DB-1:0] db_clk_en_o,
  output logic [NUM_DB-1:0] db_rst_o,
  output logic              dev_ready_o
);
  localparam int HDR_W   = 1 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_REV    = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_OLDREV = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_BUILD  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_SN_LO  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_SN_HI  = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_LINK   = ADDR_W'(8'h3C);

  localparam logic [DATA_W-1:0] ID_WORD  = DATA_W'(32'h0A52_2D27);
  localparam logic [DATA_W-1:0] REV_WORD = DATA_W'(32'h2012_2114);

  logic [2:0] sclk_q, cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[1:0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  wire sck_rise = sclk_q[1] & ~sclk_q[2];
  wire sck_fall = ~sclk_q[1] & sclk_q[2];
  wire sel      = ~cs_q[1];

  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-2:0] rx;
  logic [DATA_W-1:0]  tx;

  wire [FRAME_W-1:0] frame   = {rx, mosi_q[1]};
  wire               wr_fire = sel & sck_rise & (bit_cnt == CNT_W'(FRAME_W - 1)) & frame[FRAME_W-1];
  wire [ADDR_W-1:0]  wr_addr = frame[FRAME_W-2 -: ADDR_W];
  wire [DATA_W-1:0]  wr_data = frame[DATA_W-1:0];
  wire [ADDR_W-1:0]  rd_addr = rx[ADDR_W-1:0];
  wire               rd_req  = ~rx[HDR_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      rx      <= '0;
    end else if (!sel) begin
      bit_cnt <= '0;
    end else if (sck_rise && bit_cnt < CNT_W'(FRAME_W)) begin
      bit_cnt <= bit_cnt + 1'b1;
      rx      <= frame[FRAME_W-2:0];
    end

  logic [DATA_W-1:0] sn_lo, sn_hi;
  logic [DATA_W-1:0] rd_data;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_ID:     rd_data = ID_WORD;
      A_REV:    rd_data = REV_WORD;
      A_OLDREV: rd_data = REV_WORD;
      A_BUILD:  rd_data = BUILD_ID;
      A_CTRL: begin
        rd_data[0]   = pll_ref_en_o;
        rd_data[2]   = clk_run_i;
        rd_data[5:4] = db_clk_en_o[1:0];
        rd_data[7:6] = db_rst_o[1:0];
      end
      A_SN_LO:  rd_data = sn_lo;
      A_SN_HI:  rd_data = sn_hi;
      A_LINK:   rd_data[0] = partner_i;
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      tx <= '0;
    else if (!sel)
      tx <= '0;
    else if (sck_fall) begin
      if (bit_cnt == CNT_W'(HDR_W))
        tx <= rd_req ? rd_data : '0;
      else if (bit_cnt > CNT_W'(HDR_W))
        tx <= {tx[DATA_W-2:0], 1'b0};
    end

  assign spi_miso = sel & tx[DATA_W-1];

  function automatic logic pair_next(logic cur, logic on, logic off);
    return (on ^ off) ? on : cur;
  endfunction

  wire ctrl_wr = wr_fire & (wr_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pll_ref_en_o <= 1'b0;
      db_clk_en_o  <= '0;
      db_rst_o     <= '1;
      dev_ready_o  <= 1'b0;
      sn_lo        <= '0;
      sn_hi        <= '0;
    end else if (wr_fire) begin
      if (ctrl_wr) begin
        pll_ref_en_o <= pair_next(pll_ref_en_o, wr_data[10], wr_data[14]);
        for (int i = 0; i < NUM_DB; i++) begin
          db_clk_en_o[i] <= pair_next(db_clk_en_o[i], wr_data[8+i], wr_data[12+i]);
          db_rst_o[i]    <= pair_next(db_rst_o[i], wr_data[20+i], wr_data[16+i]);
        end
      end
      if (wr_addr == A_SN_LO) sn_lo <= wr_data;
      if (wr_addr == A_SN_HI) sn_hi <= wr_data;
      if (wr_addr == A_LINK)  dev_ready_o <= wr_data[0];
    end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));

  p_pll_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wr_data[10] && !wr_data[14] |=> pll_ref_en_o);

  p_pll_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !wr_data[10] && wr_data[14] |=> !pll_ref_en_o);

  p_db0_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wr_data[20] && !wr_data[16] |=> db_rst_o[0]);

  p_pair_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && (wr_data[10] == wr_data[14]) |=> $stable(pll_ref_en_o));

  p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable({pll_ref_en_o, db_clk_en_o, db_rst_o, dev_ready_o, sn_lo, sn_hi}));

  p_miso_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel && bit_cnt < CNT_W'(HDR_W) && !(sck_fall && bit_cnt == CNT_W'(HDR_W)) |-> !spi_miso);
endmodule

// File: tb/spi_ctrl_regs_bench.sv
module spi_ctrl_regs_bench;
  localparam logic [31:0] BID = 32'h91C0_FFEE;

  logic clk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
  logic clk_run_i = 0, partner_i = 0;
  logic spi_miso, pll_ref_en_o, dev_ready_o;
  logic [1:0] db_clk_en_o, db_rst_o;

  spi_ctrl_regs #(.BUILD_ID(BID)) u_spi_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .clk_run_i(clk_run_i),
    .partner_i(partner_i), .pll_ref_en_o(pll_ref_en_o),
    .db_clk_en_o(db_clk_en_o), .db_rst_o(db_rst_o), .dev_ready_o(dev_ready_o));

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit m_pll = 0, m_rdy = 0;
  bit [1:0] m_clk = 0, m_rst = 2'b11;
  bit [31:0] m_lo = 0, m_hi = 0;
  int pend = 0;
  bit [14:0] p_addr;
  bit [31:0] p_data;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit pr(bit cur, bit on, bit off);
    return (on != off) ? on : cur;
  endfunction

  function automatic void apply(bit [14:0] a, bit [31:0] d);
    case (a)
      15'h20: begin
        m_pll = pr(m_pll, d[10], d[14]);
        for (int i = 0; i < 2; i++) begin
          m_clk[i] = pr(m_clk[i], d[8+i], d[12+i]);
          m_rst[i] = pr(m_rst[i], d[20+i], d[16+i]);
        end
      end
      15'h34: m_lo = d;
      15'h38: m_hi = d;
      15'h3C: m_rdy = d[0];
      default: ;
    endcase
  endfunction

  function automatic bit [31:0] expect_rd(bit [14:0] a);
    case (a)
      15'h00: return 32'h0A522D27;
      15'h04, 15'h08: return 32'h20122114;
      15'h10: return BID;
      15'h20: return {24'b0, m_rst, m_clk, 1'b0, clk_run_i, 1'b0, m_pll};
      15'h34: return m_lo;
      15'h38: return m_hi;
      15'h3C: return {31'b0, partner_i};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk)
    if (pend > 0) begin
      pend--;
      if (pend == 0) apply(p_addr, p_data);
    end

  always @(negedge clk)
    if (rst_n) begin
      chk("R5 pll_ref_en_o", 32'(pll_ref_en_o), 32'(m_pll));
      chk("R6 db_clk_en_o", 32'(db_clk_en_o), 32'(m_clk));
      chk("R7 db_rst_o", 32'(db_rst_o), 32'(m_rst));
      chk("R10 dev_ready_o", 32'(dev_ready_o), 32'(m_rdy));
      if (spi_cs_n) chk("R2 miso idle", 32'(spi_miso), 32'h0);
    end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(bit wr, bit [14:0] a, bit [31:0] d, int nbits, string tag,
                      bit check_rd);
    bit [47:0] f = {wr, a, d};
    bit [31:0] got = 0;
    bit [31:0] exp;
    @(negedge clk);
    spi_cs_n = 0;
    for (int k = 0; k < nbits; k++) begin
      spi_mosi = (k < 48) ? f[47-k] : 1'b1;
      wait_n(4);
      if (k >= 16 && k < 48) got = {got[30:0], spi_miso};
      else if (k < 16) chk("R2 miso header", 32'(spi_miso), 32'h0);
      if (k == 16) exp = expect_rd(a);
      spi_sclk = 1;
      if (k == 47 && wr) begin
        p_addr = a; p_data = d; pend = 3;
      end
      wait_n(4);
      spi_sclk = 0;
    end
    wait_n(4);
    spi_cs_n = 1;
    spi_mosi = 0;
    wait_n(8);
    if (check_rd) chk(tag, got, exp);
  endtask

  task automatic wr32(bit [14:0] a, bit [31:0] d);
    xfer(1'b1, a, d, 48, "R1 write", 1'b0);
  endtask

  task automatic rd32(bit [14:0] a, string tag);
    xfer(1'b0, a, 32'h0, 48, tag, 1'b1);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    chk("R12 reset state", {26'b0, pll_ref_en_o, db_clk_en_o, db_rst_o, dev_ready_o},
        {26'b0, 1'b0, 2'b00, 2'b11, 1'b0});

    rd32(15'h00, "R3 signature");
    rd32(15'h04, "R3 revision");
    rd32(15'h08, "R3 oldest revision");
    rd32(15'h10, "R4 build id");
    rd32(15'h34, "R9 serial lo reset");
    rd32(15'h20, "R5 ctrl readback reset");

    wr32(15'h20, 32'h1 << 10);
    clk_run_i = 1;
    rd32(15'h20, "R5 pll on + clk_run");
    wr32(15'h20, 32'h1 << 14);
    clk_run_i = 0;
    rd32(15'h20, "R5 pll off");

    wr32(15'h20, (32'h1 << 8) | (32'h1 << 17));
    rd32(15'h20, "R6 R7 db0 clk on db1 out of reset");
    wr32(15'h20, (32'h1 << 9) | (32'h1 << 16) | (32'h1 << 12));
    rd32(15'h20, "R6 R7 swap");
    wr32(15'h20, (32'h1 << 13) | (32'h1 << 20) | (32'h1 << 21));
    rd32(15'h20, "R7 both reset");

    wr32(15'h20, 32'h1 << 10);
    wr32(15'h20, (32'h1 << 10) | (32'h1 << 14) | (32'h1 << 9) | (32'h1 << 13));
    rd32(15'h20, "R8 both bits hold");
    wr32(15'h20, 32'h0);
    rd32(15'h20, "R8 no bits hold");

    wr32(15'h34, 32'hDEAD_BEEF);
    wr32(15'h38, 32'h0000_1234);
    rd32(15'h34, "R9 serial lo");
    rd32(15'h38, "R9 serial hi");

    wr32(15'h3C, 32'h1);
    rd32(15'h3C, "R10 partner 0");
    partner_i = 1;
    rd32(15'h3C, "R10 partner 1");
    wr32(15'h3C, 32'h0);

    wr32(15'h00, 32'hFFFF_FFFF);
    rd32(15'h00, "R11 signature write ignored");
    wr32(15'h44, 32'hFFFF_FFFF);
    rd32(15'h44, "R11 unmapped read zero");
    rd32(15'h7FFF, "R11 high unmapped");

    xfer(1'b1, 15'h34, 32'h1111_2222, 30, "R13", 1'b0);
    rd32(15'h34, "R13 aborted write");
    xfer(1'b1, 15'h3C, 32'h1, 47, "R13", 1'b0);

    xfer(1'b1, 15'h38, 32'hA5A5_0F0F, 53, "R1", 1'b0);
    rd32(15'h38, "R1 extra clocks ignored");
    xfer(1'b0, 15'h10, 32'h0, 56, "R2 long read", 1'b1);

    wait_n(10);
    finish_run();
  end
endmodule